// File: doc/BRIEF.md
# Soft Interrupt Priority Filter

This block keeps a 17-bit register of software interrupt requests and a 4-bit processor interrupt level. It drives one pending line per request bit, and the level filters those lines. Software updates the request register through a small register port. The port offers three write addresses: one that stores the data as given, one that ORs the data into the stored value, and one that clears the bits the data marks. A separate port loads the interrupt level. A timer-match strobe raises the top request bit by itself.

The two end bits, bit 0 and bit 16, are the timer-style requests. They share one fixed gate: they are visible only while the level is below 14. Each middle bit 1 to 15 is visible only while its own index is above the level. The pending lines are decoded without registers from the stored request and level values, so a downstream trap unit sees the effect of any write one clock after it.

Top module: `soft_irq_filter`

## Requirements
- R1: While reset is asserted, and after it is released, the request register and the level hold zero, so every pending line is low and reads return zero.
- R2: A write to address 0 stores the 17 data bits as the new request value. A read at address 0 returns that value zero-extended to 32 bits.
- R3: A write to address 1 stores the OR of the data with the current request value.
- R4: A write to address 2 stores the current request value ANDed with the inverse of the data.
- R5: For each bit i from 1 to 15, pending line i is high exactly when request bit i is set and i is strictly greater than the level.
- R6: Pending lines 0 and 16 are high exactly when their request bit is set and the level is less than 14.
- R7: A timer-match pulse sets request bit 16 and leaves the other bits as they are. In a cycle that also carries a register write, the write result is taken first and bit 16 is then ORed in.
- R8: A write to address 3 changes nothing. Reads at addresses 1, 2 and 3 return zero.
- R9: A level write loads the new level, which appears on the level output one cycle later. The pending lines reflect the new level in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the request register port |
| reg_addr | input | 2 | 0 store, 1 OR in, 2 clear bits, 3 no effect; also selects the read |
| reg_wdata | input | 17 | Write data |
| reg_rdata | output | 32 | Read data: the request value at address 0, zero elsewhere |
| lvl_wr_en | input | 1 | Write strobe for the interrupt level |
| lvl_wdata | input | 4 | New interrupt level |
| lvl_q | output | 4 | Current interrupt level |
| timer_match | input | 1 | Sets request bit 16 |
| pend | output | 17 | Filtered pending lines, one per request bit |

## Verification
Every write, level load and timer pulse is due exactly one clock after the edge that captures it. At that point the read data and the pending lines respond without delay to the stored values. The bench drives each stimulus half a cycle before a rising edge. At the next falling edge it drops the strobes and points the read address at 0, then compares a moment later. Reads at the alias addresses are combinational, so they are compared in the same half cycle in which the address is driven.

// File: rtl/soft_irq_filter.sv
module soft_irq_filter #(
  parameter int DATA_W  = 32,
  parameter int NBITS   = 17,
  parameter int LVL_W   = 4,
  parameter int HI_GATE = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [NBITS-1:0]  reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              lvl_wr_en,
  input  logic [LVL_W-1:0]  lvl_wdata,
  output logic [LVL_W-1:0]  lvl_q,
  input  logic              timer_match,
  output logic [NBITS-1:0]  pend
);
  localparam int TOP = NBITS - 1;

  logic [NBITS-1:0] sint_q, wr_val, sint_d;
  logic [LVL_W-1:0] pil_q;

  always_comb begin
    case (reg_addr)
      2'd0:    wr_val = reg_wdata;
      2'd1:    wr_val = sint_q | reg_wdata;
      2'd2:    wr_val = sint_q & ~reg_wdata;
      default: wr_val = sint_q;
    endcase
  end

  assign sint_d = (reg_wr_en ? wr_val : sint_q) | {timer_match, {TOP{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sint_q <= '0;
      pil_q  <= '0;
    end else begin
      sint_q <= sint_d;
      if (lvl_wr_en) pil_q <= lvl_wdata;
    end
  end

  generate
    for (genvar i = 0; i < NBITS; i++) begin : g_gate
      if (i == 0 || i == TOP) begin : g_fixed
        assign pend[i] = sint_q[i] && (int'(pil_q) < HI_GATE);
      end else begin : g_ranked
        assign pend[i] = sint_q[i] && (int'(pil_q) < i);
      end
    end
  endgenerate

  assign reg_rdata = (reg_addr == 2'd0) ? DATA_W'(sint_q) : '0;
  assign lvl_q     = pil_q;
endmodule

// File: rtl/soft_irq_filter_chk.sv
module soft_irq_filter_chk #(
  parameter int DATA_W  = 32,
  parameter int NBITS   = 17,
  parameter int LVL_W   = 4,
  parameter int HI_GATE = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [1:0]        reg_addr,
  input logic [NBITS-1:0]  reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              lvl_wr_en,
  input logic [LVL_W-1:0]  lvl_wdata,
  input logic [LVL_W-1:0]  lvl_q,
  input logic              timer_match,
  input logic [NBITS-1:0]  pend,
  input logic [NBITS-1:0]  sint_q
);
  assert_rst_R1: assert property (@(posedge clk) !rst_n |-> (pend == '0 && lvl_q == '0));

  assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 2'd0 && !timer_match) |=> sint_q == $past(reg_wdata));

  assert_or_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 2'd1) |=> (sint_q & $past(reg_wdata)) == $past(reg_wdata));

  assert_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 2'd2 && !timer_match) |=> (sint_q & $past(reg_wdata)) == '0);

  generate
    for (genvar i = 1; i < NBITS - 1; i++) begin : g_rank
      assert_rank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pend[i] |-> (sint_q[i] && int'(lvl_q) < i));
    end
  endgenerate

  assert_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(lvl_q) >= HI_GATE) |-> (!pend[0] && !pend[NBITS-1]));

  assert_timer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timer_match |=> sint_q[NBITS-1]);

  assert_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((!reg_wr_en || reg_addr == 2'd3) && !timer_match) |=> $stable(sint_q));

  assert_alias_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != 2'd0) |-> reg_rdata == '0);

  assert_lvl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr_en |=> lvl_q == $past(lvl_wdata));
endmodule

bind soft_irq_filter soft_irq_filter_chk #(
  .DATA_W(DATA_W), .NBITS(NBITS), .LVL_W(LVL_W), .HI_GATE(HI_GATE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lvl_wr_en(lvl_wr_en),
  .lvl_wdata(lvl_wdata), .lvl_q(lvl_q), .timer_match(timer_match),
  .pend(pend), .sint_q(sint_q)
);

// File: tb/tb_soft_irq_filter.sv
module tb_soft_irq_filter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr_en = 0;
  logic [1:0]  reg_addr = 0;
  logic [16:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        lvl_wr_en = 0;
  logic [3:0]  lvl_wdata = 0;
  logic [3:0]  lvl_q;
  logic        timer_match = 0;
  logic [16:0] pend;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  soft_irq_filter dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lvl_wr_en(lvl_wr_en),
    .lvl_wdata(lvl_wdata), .lvl_q(lvl_q), .timer_match(timer_match), .pend(pend)
  );

  // vector: {addr[39:38], wdata[37:21], level[20:17], expected request[16:0]}
  localparam logic [39:0] VEC [12] = '{
    {2'd0, 17'h1FFFF, 4'd0,  17'h1FFFF},
    {2'd2, 17'h0AAAA, 4'd0,  17'h15555},
    {2'd1, 17'h00002, 4'd5,  17'h15557},
    {2'd0, 17'h00000, 4'd13, 17'h00000},
    {2'd0, 17'h10001, 4'd13, 17'h10001},
    {2'd0, 17'h10001, 4'd14, 17'h10001},
    {2'd1, 17'h08000, 4'd14, 17'h18001},
    {2'd1, 17'h08000, 4'd15, 17'h18001},
    {2'd3, 17'h1FFFF, 4'd0,  17'h18001},
    {2'd2, 17'h1FFFF, 4'd7,  17'h00000},
    {2'd0, 17'h0FF00, 4'd7,  17'h0FF00},
    {2'd0, 17'h000FF, 4'd7,  17'h000FF}
  };

  function automatic logic [16:0] gate(input logic [16:0] s, input logic [3:0] l);
    logic [16:0] p;
    for (int i = 0; i < 17; i++)
      if (i == 0 || i == 16) p[i] = s[i] && (l < 4'd14);
      else                   p[i] = s[i] && (int'(l) < i);
    return p;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] a, input logic [16:0] d, input logic we,
                      input logic [3:0] l, input logic le, input logic tm);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = we;
    lvl_wdata = l; lvl_wr_en = le; timer_match = tm;
    @(negedge clk);
    reg_wr_en = 0; lvl_wr_en = 0; timer_match = 0; reg_addr = 2'd0;
    #0.5;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    check("R1 pend in reset", 32'(pend), 0);
    check("R1 level in reset", 32'(lvl_q), 0);
    check("R1 read in reset", reg_rdata, 0);
    rst_n = 1;
    @(negedge clk); #0.5;
    check("R1 read after reset", reg_rdata, 0);

    for (int v = 0; v < 12; v++) begin
      step(VEC[v][39:38], VEC[v][37:21], 1'b1, VEC[v][20:17], 1'b1, 1'b0);
      check("R2 R3 R4 R8 request value", reg_rdata, 32'(VEC[v][16:0]));
      check("R5 R6 R9 pending lines", 32'(pend), 32'(gate(VEC[v][16:0], VEC[v][20:17])));
    end
    check("R9 level output", 32'(lvl_q), 7);

    for (int a = 1; a < 4; a++) begin
      reg_addr = 2'(a); #0.5;
      check("R8 alias read zero", reg_rdata, 0);
    end
    reg_addr = 0; #0.5;

    step(2'd0, 17'h0, 1'b0, 4'd0, 1'b0, 1'b1);
    check("R7 timer sets top bit only", reg_rdata, 32'h100FF);
    check("R6 top pending at level 7", 32'(pend), 32'h10001);

    step(2'd2, 17'h1FFFF, 1'b1, 4'd0, 1'b0, 1'b1);
    check("R7 timer over clear write", reg_rdata, 32'h10000);

    step(2'd0, 17'h0, 1'b0, 4'd14, 1'b1, 1'b0);
    check("R6 top masked at level 14", 32'(pend), 0);
    check("R9 level loads 14", 32'(lvl_q), 14);

    step(2'd0, 17'h1FFFF, 1'b1, 4'd15, 1'b1, 1'b0);
    check("R5 all ranked masked at level 15", 32'(pend), 0);

    @(negedge clk); rst_n = 0; #0.5;
    check("R1 async reset clears request", reg_rdata, 0);
    check("R1 async reset clears level", 32'(lvl_q), 0);
    rst_n = 1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule